// File: doc/BRIEF.md
# Accumulator ALU with Carry Flags

This block is the arithmetic and logic engine of an 8-bit accumulator machine. Each cycle it can take one operation: an opcode, the accumulator value, a second operand (which doubles as the B register for multiply and divide), and the incoming carry and auxiliary-carry flags. One clock later it returns a new accumulator value, a new B value and the carry, auxiliary carry, overflow, zero and inequality indications. The surrounding core writes these back as it needs to. Fetching operands from a register file and working out branch targets are left to other logic.

The operation set covers binary add with and without carry-in, and subtract with borrow. It also covers increment and decrement, and the bitwise AND, OR and XOR, clear and complement. Nibble swap, four rotate forms, BCD decimal adjust, an 8x8 multiply into the B:A pair and an 8/8 divide are included. A compare serves compare-and-branch: it reports less-than in carry and inequality on its own output, and it leaves both operands as they were.

Top module: `acc_alu`

## Requirements
- R1: Results are registered. `res_valid` is high exactly one cycle after a cycle with `op_valid` high, and the result fields belong to that operation. While `rst` is high, every output is 0.
- R2: Opcode 0 (add) returns A+X and ignores `cy_in`. Opcode 1 (add with carry) returns A+X+`cy_in`. Both set carry on a carry out of bit 7, auxiliary carry on a carry out of bit 3, and overflow on two's-complement overflow.
- R3: Opcode 2 (subtract with borrow) returns A-X-`cy_in`. It sets carry on a borrow out of bit 7, auxiliary carry on a borrow out of bit 3, and overflow on two's-complement overflow.
- R4: Opcode 3 (increment) and opcode 4 (decrement) wrap modulo 256. Carry and auxiliary carry pass through unchanged.
- R5: Opcodes 5, 6 and 7 return A AND X, A OR X and A XOR X. Opcode 8 returns 0 and opcode 9 returns NOT A. Carry passes through.
- R6: Opcode 10 swaps A[3:0] with A[7:4]. Opcode 11 rotates left with A7 into A0. Opcode 12 rotates left through carry, with A7 into carry and carry into A0. Opcode 13 rotates right with A0 into A7. Opcode 14 rotates right through carry, with A0 into carry and carry into A7.
- R7: Opcode 15 (decimal adjust) first adds 06h when the low nibble is above 9 or `ac_in` is set. It then adds 60h when carry is set, when the first step carried out, or when the new high nibble is above 9. That second step sets carry; otherwise carry keeps `cy_in`.
- R8: Opcode 16 (multiply) puts the low byte of A*X in the accumulator result and the high byte in `res_b`. It clears carry and sets overflow exactly when the product exceeds 255.
- R9: Opcode 17 (divide) returns the quotient A/X in the accumulator result and the remainder in `res_b`, with overflow 0. When X is 0 it sets overflow and leaves both results undefined. Carry is always cleared.
- R10: Opcode 18 (compare) returns A and X unchanged. It sets carry when A < X (unsigned), clears carry otherwise, and drives `ne_out` high exactly when A differs from X. `ne_out` is 0 for every other opcode.
- R11: `zero_out` is high exactly when the accumulator result is 0. `res_b` equals X for every opcode other than multiply and divide, and overflow is 0 for every opcode not listed as setting it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation select (codes in R2 to R10) |
| acc_in | input | 8 | Accumulator operand A |
| opb_in | input | 8 | Second operand X, also B for multiply and divide |
| cy_in | input | 1 | Incoming carry flag |
| ac_in | input | 1 | Incoming auxiliary carry flag |
| res_valid | output | 1 | Result fields valid |
| res_acc | output | 8 | New accumulator value |
| res_b | output | 8 | New B value |
| cy_out | output | 1 | Carry / borrow / less-than |
| ac_out | output | 1 | Auxiliary carry (bit 3) |
| ov_out | output | 1 | Overflow |
| zero_out | output | 1 | Accumulator result is zero |
| ne_out | output | 1 | Compare found the operands unequal |

## Verification
The bench checks that plain add ignores a set carry-in. A design that fed it in would return one more than expected. Subtract is tested at 00h-01h and at 80h-01h, where an inverted borrow or a wrongly formed overflow would flip the flag. Decimal adjust is tested with a low-nibble carry that pushes the high nibble past 9, so that a single combined correction would miss the 60h step. Multiply is tested with products just above and below 256 so that overflow and the B byte are checked, and divide is tested with a zero divisor, where the flags would be wrong if the zero case were not detected. Compare is tested at less-than, equal and greater-than, which shows whether the operand order was swapped or whether the operands were overwritten.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_INC  = 5'd3,
    OP_DEC  = 5'd4,
    OP_AND  = 5'd5,
    OP_OR   = 5'd6,
    OP_XOR  = 5'd7,
    OP_CLR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_SWAP = 5'd10,
    OP_RL   = 5'd11,
    OP_RLC  = 5'd12,
    OP_RR   = 5'd13,
    OP_RRC  = 5'd14,
    OP_DA   = 5'd15,
    OP_MUL  = 5'd16,
    OP_DIV  = 5'd17,
    OP_CMP  = 5'd18
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int NIB = W / 2;

  logic [W-1:0]   b_eff;
  logic           c_eff;
  logic [W:0]     full;
  logic [NIB:0]   low;

  // subtraction as a + ~b + ~borrow; carry out then means "no borrow"
  always_comb begin
    b_eff = sub ? ~b : b;
    c_eff = sub ? ~cin : cin;
    full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    low   = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
    sum   = full[W-1:0];
    cy    = sub ? ~full[W] : full[W];
    ac    = sub ? ~low[NIB] : low[NIB];
    ov    = (a[W-1] == b_eff[W-1]) && (full[W-1] != a[W-1]);
  end
endmodule

// File: rtl/alu_shift_logic.sv
module alu_shift_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cy
);
  localparam int NIB = W / 2;

  always_comb begin
    res = a;
    cy  = cin;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      OP_SWAP: res = {a[NIB-1:0], a[W-1:NIB]};
      OP_RL:   res = {a[W-2:0], a[W-1]};
      OP_RLC: begin
        res = {a[W-2:0], cin};
        cy  = a[W-1];
      end
      OP_RR:   res = {a[0], a[W-1:1]};
      OP_RRC: begin
        res = {cin, a[W-1:1]};
        cy  = a[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cin,
  input  logic         acin,
  output logic [W-1:0] res,
  output logic         cy
);
  localparam int           NIB    = W / 2;
  localparam logic [W:0]   LO_ADJ = (W+1)'(6);
  localparam logic [W:0]   HI_ADJ = LO_ADJ << NIB;
  localparam logic [NIB-1:0] DMAX = NIB'(9);

  logic         lo_fix, hi_fix;
  logic [W:0]   step1, step2;

  always_comb begin
    lo_fix = acin || (a[NIB-1:0] > DMAX);
    step1  = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
    hi_fix = cin || step1[W] || (step1[W-1:NIB] > DMAX);
    step2  = {1'b0, step1[W-1:0]} + (hi_fix ? HI_ADJ : '0);
    res    = step2[W-1:0];
    cy     = hi_fix || step2[W] || cin;
  end
endmodule

// File: rtl/alu_muldiv.sv
module alu_muldiv #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] prod_lo,
  output logic [W-1:0] prod_hi,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic         div_zero
);
  logic [2*W-1:0] prod;
  logic [W-1:0]   part [0:W];

  assign prod     = {{W{1'b0}}, a} * {{W{1'b0}}, b};
  assign prod_lo  = prod[W-1:0];
  assign prod_hi  = prod[2*W-1:W];
  assign div_zero = (b == '0);
  assign part[0]  = '0;

  // restoring divider, one stage per quotient bit, MSB first
  for (genvar i = 0; i < W; i++) begin : g_div
    logic [W:0] shifted;
    logic       fits;
    assign shifted = {part[i], a[W-1-i]};
    assign fits    = (shifted >= {1'b0, b});
    assign part[i+1] = fits ? W'(shifted - {1'b0, b}) : shifted[W-1:0];
    assign quot[W-1-i] = fits;
  end

  assign rem = part[W];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         op_valid,
  input  logic [4:0]   op_code,
  input  logic [W-1:0] acc_in,
  input  logic [W-1:0] opb_in,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic         res_valid,
  output logic [W-1:0] res_acc,
  output logic [W-1:0] res_b,
  output logic         cy_out,
  output logic         ac_out,
  output logic         ov_out,
  output logic         zero_out,
  output logic         ne_out
);
  alu_op_e      op;
  logic         as_sub, as_cin, as_cy, as_ac, as_ov;
  logic [W-1:0] as_sum;
  logic [W-1:0] sl_res;
  logic         sl_cy;
  logic [W-1:0] da_res;
  logic         da_cy;
  logic [W-1:0] md_lo, md_hi, md_q, md_r;
  logic         md_dz;

  logic [W-1:0] n_acc, n_b;
  logic         n_cy, n_ac, n_ov, n_ne;

  assign op     = alu_op_e'(op_code);
  assign as_sub = (op == OP_SUBB) || (op == OP_CMP);
  assign as_cin = ((op == OP_ADDC) || (op == OP_SUBB)) ? cy_in : 1'b0;

  alu_addsub #(.W(W)) u_addsub (
    .a(acc_in), .b(opb_in), .cin(as_cin), .sub(as_sub),
    .sum(as_sum), .cy(as_cy), .ac(as_ac), .ov(as_ov)
  );

  alu_shift_logic #(.W(W)) u_shl (
    .op(op), .a(acc_in), .b(opb_in), .cin(cy_in),
    .res(sl_res), .cy(sl_cy)
  );

  alu_decadj #(.W(W)) u_da (
    .a(acc_in), .cin(cy_in), .acin(ac_in),
    .res(da_res), .cy(da_cy)
  );

  alu_muldiv #(.W(W)) u_md (
    .a(acc_in), .b(opb_in),
    .prod_lo(md_lo), .prod_hi(md_hi), .quot(md_q), .rem(md_r), .div_zero(md_dz)
  );

  always_comb begin
    n_acc = acc_in;
    n_b   = opb_in;
    n_cy  = cy_in;
    n_ac  = ac_in;
    n_ov  = 1'b0;
    n_ne  = 1'b0;
    case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        n_acc = as_sum;
        n_cy  = as_cy;
        n_ac  = as_ac;
        n_ov  = as_ov;
      end
      OP_INC: n_acc = acc_in + W'(1);
      OP_DEC: n_acc = acc_in - W'(1);
      OP_AND, OP_OR, OP_XOR, OP_CLR, OP_CPL,
      OP_SWAP, OP_RL, OP_RLC, OP_RR, OP_RRC: begin
        n_acc = sl_res;
        n_cy  = sl_cy;
      end
      OP_DA: begin
        n_acc = da_res;
        n_cy  = da_cy;
      end
      OP_MUL: begin
        n_acc = md_lo;
        n_b   = md_hi;
        n_cy  = 1'b0;
        n_ov  = |md_hi;
      end
      OP_DIV: begin
        n_cy = 1'b0;
        if (md_dz) begin
          n_ov = 1'b1;
        end else begin
          n_acc = md_q;
          n_b   = md_r;
        end
      end
      OP_CMP: begin
        n_cy = as_cy;
        n_ne = (acc_in != opb_in);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_acc   <= '0;
      res_b     <= '0;
      cy_out    <= 1'b0;
      ac_out    <= 1'b0;
      ov_out    <= 1'b0;
      zero_out  <= 1'b0;
      ne_out    <= 1'b0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        res_acc  <= n_acc;
        res_b    <= n_b;
        cy_out   <= n_cy;
        ac_out   <= n_ac;
        ov_out   <= n_ov;
        zero_out <= (n_acc == '0);
        ne_out   <= n_ne;
      end
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         op_valid,
  input logic [4:0]   op_code,
  input logic [W-1:0] acc_in,
  input logic [W-1:0] opb_in,
  input logic         res_valid,
  input logic [W-1:0] res_acc,
  input logic [W-1:0] res_b,
  input logic         cy_out,
  input logic         ov_out,
  input logic         zero_out,
  input logic         ne_out
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    op_valid |=> res_valid);

  p_idle_follows_r1: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> !res_valid);

  // R8: multiply overflow tracks the high byte, carry cleared
  p_mul_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 5'd16) |=> (!cy_out && (ov_out == (res_b != '0))));

  p_div_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 5'd17 && opb_in == '0) |=> (ov_out && !cy_out));

  p_cmp_keeps_r10: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 5'd18) |=>
      (res_acc == $past(acc_in) && res_b == $past(opb_in) &&
       cy_out == ($past(acc_in) < $past(opb_in)) &&
       ne_out == ($past(acc_in) != $past(opb_in))));

  p_zero_flag_r11: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (zero_out == (res_acc == '0)));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
  .acc_in(acc_in), .opb_in(opb_in), .res_valid(res_valid),
  .res_acc(res_acc), .res_b(res_b), .cy_out(cy_out), .ov_out(ov_out),
  .zero_out(zero_out), .ne_out(ne_out)
);

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] acc_in = '0, opb_in = '0;
  logic       cy_in = 1'b0, ac_in = 1'b0;
  logic       res_valid;
  logic [7:0] res_acc, res_b;
  logic       cy_out, ac_out, ov_out, zero_out, ne_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct {
    string      tag;
    logic [7:0] acc, b;
    logic       cy, ac, ov, z, ne;
    bit         ab_defined;
  } exp_t;

  exp_t sbq[$];

  always #4 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opb_in(opb_in), .cy_in(cy_in), .ac_in(ac_in),
    .res_valid(res_valid), .res_acc(res_acc), .res_b(res_b),
    .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out),
    .zero_out(zero_out), .ne_out(ne_out)
  );

  function automatic exp_t model(input logic [4:0] op, input logic [7:0] a, x,
                                 input logic c, input logic h, input string tag);
    exp_t e;
    logic [8:0]  s;
    logic [15:0] p;
    logic [4:0]  lo;
    e.tag = tag; e.acc = a; e.b = x; e.cy = c; e.ac = h;
    e.ov = 0; e.ne = 0; e.ab_defined = 1;
    case (op)
      5'd0, 5'd1: begin
        s = a + x + ((op == 5'd1) ? c : 1'b0);
        lo = a[3:0] + x[3:0] + ((op == 5'd1) ? c : 1'b0);
        e.acc = s[7:0]; e.cy = s[8]; e.ac = lo[4];
        e.ov = (a[7] == x[7]) && (s[7] != a[7]);
      end
      5'd2: begin
        s = {1'b0, a} - {1'b0, x} - c;
        e.acc = s[7:0]; e.cy = ({1'b0, a} < ({1'b0, x} + c));
        e.ac = ({1'b0, a[3:0]} < ({1'b0, x[3:0]} + c));
        e.ov = (a[7] != x[7]) && (s[7] != a[7]);
      end
      5'd3: e.acc = a + 8'd1;
      5'd4: e.acc = a - 8'd1;
      5'd5: e.acc = a & x;
      5'd6: e.acc = a | x;
      5'd7: e.acc = a ^ x;
      5'd8: e.acc = 8'h00;
      5'd9: e.acc = ~a;
      5'd10: e.acc = {a[3:0], a[7:4]};
      5'd11: e.acc = {a[6:0], a[7]};
      5'd12: begin e.acc = {a[6:0], c}; e.cy = a[7]; end
      5'd13: e.acc = {a[0], a[7:1]};
      5'd14: begin e.acc = {c, a[7:1]}; e.cy = a[0]; end
      5'd15: begin
        s = {1'b0, a};
        if (h || a[3:0] > 4'd9) s = s + 9'h006;
        if (c || s[8] || s[7:4] > 4'd9) begin
          s = {1'b0, s[7:0]} + 9'h060;
          e.cy = 1'b1;
        end
        e.acc = s[7:0];
      end
      5'd16: begin
        p = a * x;
        e.acc = p[7:0]; e.b = p[15:8]; e.cy = 0; e.ov = (p > 16'd255);
      end
      5'd17: begin
        e.cy = 0;
        if (x == 0) begin e.ov = 1; e.ab_defined = 0; end
        else begin e.acc = a / x; e.b = a % x; end
      end
      5'd18: begin e.cy = (a < x); e.ne = (a != x); end
      default: ;
    endcase
    e.z = (e.acc == 8'h00);
    return e;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [7:0] a, x,
                       input logic c, input logic h, input string tag);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; acc_in = a; opb_in = x; cy_in = c; ac_in = h;
    sbq.push_back(model(op, a, x, c, h, tag));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_valid = 1'b0;
    end
  endtask

  // monitor: compares outputs with the oldest expected item
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && res_valid) begin
        exp_t e;
        checks++;
        if (sbq.size() == 0) begin
          errors++;
          $display("FAIL R1: unexpected result acc=%02h, expected none", res_acc);
        end else begin
          e = sbq.pop_front();
          if ((e.ab_defined && (res_acc !== e.acc || res_b !== e.b)) ||
              cy_out !== e.cy || ac_out !== e.ac || ov_out !== e.ov ||
              (e.ab_defined && zero_out !== e.z) || ne_out !== e.ne) begin
            errors++;
            $display("FAIL %s: got acc=%02h b=%02h cy=%b ac=%b ov=%b z=%b ne=%b, expected acc=%02h b=%02h cy=%b ac=%b ov=%b z=%b ne=%b",
                     e.tag, res_acc, res_b, cy_out, ac_out, ov_out, zero_out, ne_out,
                     e.acc, e.b, e.cy, e.ac, e.ov, e.z, e.ne);
          end
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: run hung after %0d cycles, expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] lf;
    repeat (4) @(negedge clk);
    #1;
    checks++;
    if (res_valid !== 0 || res_acc !== 0 || res_b !== 0 || cy_out !== 0 ||
        ac_out !== 0 || ov_out !== 0 || zero_out !== 0 || ne_out !== 0) begin
      errors++;
      $display("FAIL R1: reset state valid=%b acc=%02h, expected all zero", res_valid, res_acc);
    end
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    drive(5'd0, 8'h7F, 8'h01, 1'b1, 1'b0, "R2 add ignores carry, overflow");
    drive(5'd1, 8'hFF, 8'h00, 1'b1, 1'b0, "R2 addc wrap to zero");
    drive(5'd1, 8'h38, 8'h47, 1'b0, 1'b1, "R2 addc no carry");
    drive(5'd2, 8'h00, 8'h01, 1'b0, 1'b0, "R3 subb borrow");
    drive(5'd2, 8'h80, 8'h00, 1'b1, 1'b0, "R3 subb overflow");
    drive(5'd2, 8'h50, 8'h20, 1'b0, 1'b1, "R3 subb clean");
    drive(5'd3, 8'hFF, 8'h00, 1'b1, 1'b1, "R4 inc wrap");
    drive(5'd4, 8'h00, 8'h00, 1'b0, 1'b1, "R4 dec wrap");
    idle(1);
    drive(5'd5, 8'hF0, 8'h3C, 1'b1, 1'b0, "R5 and");
    drive(5'd6, 8'hF0, 8'h0C, 1'b0, 1'b0, "R5 or");
    drive(5'd7, 8'hAA, 8'hAA, 1'b1, 1'b1, "R5 xor zero");
    drive(5'd8, 8'h5A, 8'h11, 1'b1, 1'b0, "R5 clr");
    drive(5'd9, 8'h5A, 8'h11, 1'b0, 1'b0, "R5 cpl");
    drive(5'd10, 8'h3C, 8'h00, 1'b0, 1'b0, "R6 swap");
    drive(5'd11, 8'h81, 8'h00, 1'b0, 1'b0, "R6 rl");
    drive(5'd12, 8'h80, 8'h00, 1'b0, 1'b0, "R6 rlc");
    drive(5'd13, 8'h01, 8'h00, 1'b0, 1'b0, "R6 rr");
    drive(5'd14, 8'h01, 8'h00, 1'b1, 1'b0, "R6 rrc");
    drive(5'd15, 8'h9A, 8'h00, 1'b0, 1'b0, "R7 da both steps");
    drive(5'd15, 8'h15, 8'h00, 1'b0, 1'b1, "R7 da aux carry");
    drive(5'd15, 8'h9F, 8'h00, 1'b0, 1'b0, "R7 da low pushes high");
    drive(5'd15, 8'h12, 8'h00, 1'b1, 1'b0, "R7 da carry in");
    idle(3);
    drive(5'd16, 8'h10, 8'h10, 1'b1, 1'b0, "R8 mul 256");
    drive(5'd16, 8'h0F, 8'h11, 1'b1, 1'b0, "R8 mul 255");
    drive(5'd17, 8'hFB, 8'h12, 1'b1, 1'b0, "R9 div");
    drive(5'd17, 8'h44, 8'h00, 1'b1, 1'b0, "R9 div by zero");
    drive(5'd18, 8'h03, 8'h05, 1'b0, 1'b0, "R10 cmp less");
    drive(5'd18, 8'h05, 8'h05, 1'b1, 1'b0, "R10 cmp equal");
    drive(5'd18, 8'h09, 8'h05, 1'b1, 1'b0, "R10 cmp greater");

    lf = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] a, x;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      a = lf;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      x = lf;
      drive(5'(i % 19), a, x, a[0], x[1], "R11 sweep");
      if (i % 7 == 0) idle(1);
    end
    idle(4);

    checks++;
    if (sbq.size() != 0) begin
      errors++;
      $display("FAIL R1: %0d results missing, expected 0", sbq.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule